// File: doc/BRIEF.md
# Light-Load Mode Selector for a Buck Channel

This block sits beside the compensator of one switching regulator channel and decides which control path owns the modulator. In normal operation the PWM loop drives the modulator. When the channel has seen a long enough run of light-load switching periods, the block moves to a pulse-frequency mode. In that mode the PWM loop is switched off and the block paces single switching cycles from a comparator that watches the scaled output against its reference.

Two more comparators form a window around that reference. If the output leaves the window in either direction, the block returns the channel to PWM at once. While the channel is in pulse-frequency mode, the block also keeps the duty that those single cycles use. That duty starts from the last PWM duty and is then recomputed repeatedly from the ratio of the output code to the input code.

Top module: `pfm_mode_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `pfm_mode` is 0, `pwm_loop_en` is 1, `shot` is 0 and `pfm_duty` is 0.
- R2: The block is in PWM and `pfm_en` is 1. On the edge where the Nth consecutive `period_stb` arrives with `cur_sample` < `cur_limit` (unsigned), `pfm_mode` becomes 1 and `pwm_loop_en` becomes 0. N is `run_len`.
- R3: A `run_len` of 0 selects the default run length of 20 strobes.
- R4: A strobe whose sample is equal to or above `cur_limit` clears the run, so a full new run of N low strobes is needed.
- R5: The current sample is ignored on cycles without `period_stb`. The run is neither advanced nor cleared there.
- R6: In pulse-frequency mode, `below_norm` high with `mod_busy` low raises `shot` for exactly one cycle on the next edge. A `shot` is never asserted in two adjacent cycles.
- R7: A `below_norm` request seen while `mod_busy` is high produces no `shot`.
- R8: In pulse-frequency mode, `above_high` or `below_low` returns the block to PWM on the next edge, with `pwm_loop_en` set to 1 and no `shot`. The run is cleared, so re-entry needs N new low strobes.
- R9: While `pfm_en` is 0, the block is held in (or forced back to) PWM and the run is cleared.
- R10: On the entry edge, `pfm_duty` takes the value `pwm_duty` had at that edge.
- R11: While the block is in pulse-frequency mode with stable codes, `pfm_duty` settles to floor(`vout_code`·2^DUTY_W / `vin_code`) within 2·(DUTY_W+2) cycles. It reads all ones when `vout_code` ≥ `vin_code` or `vin_code` is 0. Outside that mode it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfm_en | input | 1 | Allows pulse-frequency mode for this channel |
| period_stb | input | 1 | One-cycle strobe per switching period |
| cur_sample | input | CUR_W | Current measured in this period |
| cur_limit | input | CUR_W | Light-load current threshold |
| run_len | input | CNT_W | Required number of consecutive low periods (0 selects the default) |
| below_low | input | 1 | Output is under the low window threshold |
| below_norm | input | 1 | Output is under the reference |
| above_high | input | 1 | Output is over the high window threshold |
| mod_busy | input | 1 | Modulator is still running a single cycle |
| pwm_duty | input | DUTY_W | Current duty of the PWM loop |
| vout_code | input | DUTY_W | Output voltage code |
| vin_code | input | DUTY_W | Input voltage code |
| pfm_mode | output | 1 | 1 while in pulse-frequency mode |
| pwm_loop_en | output | 1 | Enable for the PWM loop |
| shot | output | 1 | One-cycle request for a single switching cycle |
| pfm_duty | output | DUTY_W | Duty used for pulse-frequency cycles |

## Verification
The bench builds the block with DUTY_W = 8, CUR_W = 10 and CNT_W = 6. With an 8-bit duty, the ratio results (128, 64 and saturation at 255) can be worked out by hand, and the divider settles in a few cycles. Most runs use a run length of 4, so entry, clearing by an equal sample, and re-entry after a window exit take only a few strobes. A run length of 0 checks the built-in default of 20 at both the 19th and the 20th strobe.

// File: rtl/pfm_ctrl_pkg.sv
package pfm_ctrl_pkg;
  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_PFM = 1'b1
  } mode_e;

  localparam int DEF_RUN_LEN = 20;
endpackage

// File: rtl/pfm_run_counter.sv
// Counts consecutive light-load switching periods and flags the one that completes the run.
module pfm_run_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic             low,
  input  logic [CNT_W-1:0] need,
  output logic             reached
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign reached = adv && low && (cnt_inc >= {1'b0, need});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (adv) begin
      if (!low) begin
        cnt <= '0;
      end else if (cnt < need) begin
        cnt <= cnt_inc[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pfm_duty_div.sv
// Bit-serial restoring divider: quot = floor(num * 2^W / den), saturated.
module pfm_duty_div #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         abort,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int SW = $clog2(W + 1);

  logic          active;
  logic [SW-1:0] step;
  logic [W-1:0]  rem;
  logic [W-1:0]  den_q;
  logic [W-1:0]  q_acc;
  logic [W:0]    rem_sh;
  logic          fits;
  logic [W-1:0]  q_next;

  assign rem_sh = {rem, 1'b0};
  assign fits   = rem_sh >= {1'b0, den_q};
  assign q_next = {q_acc[W-2:0], fits};

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active <= 1'b0;
      done   <= 1'b0;
      step   <= '0;
      rem    <= '0;
      den_q  <= '0;
      q_acc  <= '0;
      if (rst) quot <= '0;
    end else begin
      done <= 1'b0;
      if (active) begin
        rem   <= fits ? W'(rem_sh - {1'b0, den_q}) : rem_sh[W-1:0];
        q_acc <= q_next;
        if (step == SW'(W - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
          quot   <= q_next;
        end else begin
          step <= step + 1'b1;
        end
      end else if (start) begin
        if (den == '0 || num >= den) begin
          done <= 1'b1;
          quot <= '1;
        end else begin
          active <= 1'b1;
          step   <= '0;
          rem    <= num;
          den_q  <= den;
          q_acc  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pfm_mode_ctrl.sv
module pfm_mode_ctrl #(
  parameter int CUR_W   = 12,
  parameter int CNT_W   = 8,
  parameter int DUTY_W  = 10,
  parameter int DEF_RUN = pfm_ctrl_pkg::DEF_RUN_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pfm_en,
  input  logic              period_stb,
  input  logic [CUR_W-1:0]  cur_sample,
  input  logic [CUR_W-1:0]  cur_limit,
  input  logic [CNT_W-1:0]  run_len,
  input  logic              below_low,
  input  logic              below_norm,
  input  logic              above_high,
  input  logic              mod_busy,
  input  logic [DUTY_W-1:0] pwm_duty,
  input  logic [DUTY_W-1:0] vout_code,
  input  logic [DUTY_W-1:0] vin_code,
  output logic              pfm_mode,
  output logic              pwm_loop_en,
  output logic              shot,
  output logic [DUTY_W-1:0] pfm_duty
);
  import pfm_ctrl_pkg::*;

  localparam logic [CNT_W-1:0] DEF_NEED = CNT_W'(DEF_RUN);

  mode_e             mode;
  logic [CNT_W-1:0]  need;
  logic              in_pfm;
  logic              leave;
  logic              reached;
  logic              div_done;
  logic [DUTY_W-1:0] div_q;

  assign in_pfm   = (mode == MODE_PFM);
  assign need     = (run_len == '0) ? DEF_NEED : run_len;
  assign leave    = above_high || below_low || !pfm_en;
  assign pfm_mode = in_pfm;

  pfm_run_counter #(.CNT_W(CNT_W)) u_run (
    .clk     (clk),
    .rst     (rst),
    .clr     (!pfm_en || (in_pfm && leave)),
    .adv     (period_stb && !in_pfm),
    .low     (cur_sample < cur_limit),
    .need    (need),
    .reached (reached)
  );

  pfm_duty_div #(.W(DUTY_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .abort (!in_pfm),
    .start (in_pfm),
    .num   (vout_code),
    .den   (vin_code),
    .done  (div_done),
    .quot  (div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= MODE_PWM;
      pwm_loop_en <= 1'b1;
      shot        <= 1'b0;
      pfm_duty    <= '0;
    end else begin
      case (mode)
        MODE_PWM: begin
          shot <= 1'b0;
          if (pfm_en && reached) begin
            mode        <= MODE_PFM;
            pwm_loop_en <= 1'b0;
            pfm_duty    <= pwm_duty;
          end
        end
        default: begin
          if (leave) begin
            mode        <= MODE_PWM;
            pwm_loop_en <= 1'b1;
            shot        <= 1'b0;
          end else begin
            shot <= below_norm && !mod_busy && !shot;
            if (div_done) pfm_duty <= div_q;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pfm_mode_ctrl_chk.sv
module pfm_mode_ctrl_chk #(
  parameter int CUR_W  = 12,
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              pfm_en,
  input logic              period_stb,
  input logic [CUR_W-1:0]  cur_sample,
  input logic [CUR_W-1:0]  cur_limit,
  input logic              below_low,
  input logic              above_high,
  input logic              mod_busy,
  input logic [DUTY_W-1:0] pwm_duty,
  input logic              pfm_mode,
  input logic              shot,
  input logic [DUTY_W-1:0] pfm_duty
);
  a_r2_entry_on_low_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(pfm_mode) |-> $past(period_stb && pfm_en && (cur_sample < cur_limit)));

  a_r6_shot_only_in_pfm: assert property (@(posedge clk) disable iff (rst)
    shot |-> pfm_mode);

  a_r6_shot_single: assert property (@(posedge clk) disable iff (rst)
    shot |=> !shot);

  a_r7_no_shot_when_busy: assert property (@(posedge clk) disable iff (rst)
    shot |-> $past(!mod_busy));

  a_r8_window_exit: assert property (@(posedge clk) disable iff (rst)
    (pfm_mode && (above_high || below_low)) |=> !pfm_mode);

  a_r9_disable_forces_pwm: assert property (@(posedge clk) disable iff (rst)
    !pfm_en |=> !pfm_mode);

  a_r10_entry_duty: assert property (@(posedge clk) disable iff (rst)
    $rose(pfm_mode) |-> (pfm_duty == $past(pwm_duty)));
endmodule

bind pfm_mode_ctrl pfm_mode_ctrl_chk #(.CUR_W(CUR_W), .DUTY_W(DUTY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pfm_en     (pfm_en),
  .period_stb (period_stb),
  .cur_sample (cur_sample),
  .cur_limit  (cur_limit),
  .below_low  (below_low),
  .above_high (above_high),
  .mod_busy   (mod_busy),
  .pwm_duty   (pwm_duty),
  .pfm_mode   (pfm_mode),
  .shot       (shot),
  .pfm_duty   (pfm_duty)
);

// File: tb/pfm_mode_ctrl_test.sv
module pfm_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CUR_W  = 10;
  localparam int CNT_W  = 6;
  localparam int DUTY_W = 8;

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pfm_en = 1'b1;
  logic              period_stb = 1'b0;
  logic [CUR_W-1:0]  cur_sample = '0;
  logic [CUR_W-1:0]  cur_limit = 10'd100;
  logic [CNT_W-1:0]  run_len = 6'd4;
  logic              below_low = 1'b0;
  logic              below_norm = 1'b0;
  logic              above_high = 1'b0;
  logic              mod_busy = 1'b0;
  logic [DUTY_W-1:0] pwm_duty = 8'h5A;
  logic [DUTY_W-1:0] vout_code = 8'd64;
  logic [DUTY_W-1:0] vin_code = 8'd128;
  logic              pfm_mode;
  logic              pwm_loop_en;
  logic              shot;
  logic [DUTY_W-1:0] pfm_duty;

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  item_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pfm_mode_ctrl #(.CUR_W(CUR_W), .CNT_W(CNT_W), .DUTY_W(DUTY_W)) uut (
    .clk(clk), .rst(rst), .pfm_en(pfm_en), .period_stb(period_stb),
    .cur_sample(cur_sample), .cur_limit(cur_limit), .run_len(run_len),
    .below_low(below_low), .below_norm(below_norm), .above_high(above_high),
    .mod_busy(mod_busy), .pwm_duty(pwm_duty), .vout_code(vout_code),
    .vin_code(vin_code), .pfm_mode(pfm_mode), .pwm_loop_en(pwm_loop_en),
    .shot(shot), .pfm_duty(pfm_duty)
  );

  // Monitor: compares queued expectations against the outputs at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      int    act;
      it = sb.pop_front();
      case (it.sel)
        0:       act = int'(pfm_mode);
        1:       act = int'(pwm_loop_en);
        2:       act = int'(shot);
        default: act = int'(pfm_duty);
      endcase
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input string req, input int sel, input int exp);
    item_t it;
    it.req = req;
    it.sel = sel;
    it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic strobe(input int cur);
    cur_sample = CUR_W'(cur);
    period_stb = 1'b1;
    tick();
    period_stb = 1'b0;
  endtask

  task automatic low_run(input int n);
    for (int i = 0; i < n; i++) strobe(10);
  endtask

  function automatic int ratio(input int vo, input int vi);
    if (vi == 0 || vo >= vi) return 255;
    return (vo * 256) / vi;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    push("R1", 0, 0); push("R1", 1, 1); push("R1", 2, 0); push("R1", 3, 0);
    tick();
    rst = 1'b0;

    // R2 and R5: three low strobes, then high samples without strobe
    low_run(3);
    cur_sample = 10'd500;
    tick(); tick(); tick();
    push("R5", 0, 0);
    strobe(10);
    push("R2", 0, 1); push("R2", 1, 0);
    push("R10", 3, 'h5A);

    // R11 ratio recalculation
    repeat (25) tick();
    push("R11", 3, ratio(64, 128));
    vout_code = 8'd200; vin_code = 8'd100;
    repeat (25) tick();
    push("R11", 3, ratio(200, 100));
    vout_code = 8'd50; vin_code = 8'd200;
    repeat (25) tick();
    push("R11", 3, ratio(50, 200));

    // R6 and R7 single-cycle triggers
    below_norm = 1'b1;
    tick(); push("R6", 2, 1);
    tick(); push("R6", 2, 0);
    mod_busy = 1'b1;
    tick(); push("R7", 2, 0);
    tick(); push("R7", 2, 0);
    mod_busy = 1'b0;
    tick(); push("R6", 2, 1);
    below_norm = 1'b0;
    tick(); push("R6", 2, 0);

    // R8 exit on high window, no shot on exit, run cleared
    above_high = 1'b1; below_norm = 1'b1;
    tick();
    push("R8", 0, 0); push("R8", 1, 1); push("R8", 2, 0);
    above_high = 1'b0; below_norm = 1'b0;
    tick();
    push("R11", 3, ratio(50, 200));
    low_run(3);
    push("R8", 0, 0);
    strobe(10);
    push("R8", 0, 1);
    below_low = 1'b1;
    tick(); push("R8", 0, 0);
    below_low = 1'b0;

    // R4 equal sample clears the run
    low_run(3);
    strobe(100);
    low_run(3);
    push("R4", 0, 0);
    strobe(10);
    push("R4", 0, 1);
    below_low = 1'b1;
    tick(); below_low = 1'b0;

    // R9 disable holds PWM, forces exit, clears run
    pfm_en = 1'b0;
    low_run(6);
    push("R9", 0, 0);
    pfm_en = 1'b1;
    low_run(4);
    push("R9", 0, 1);
    pfm_en = 1'b0;
    tick(); push("R9", 0, 0); push("R9", 1, 1);
    pfm_en = 1'b1;
    low_run(3);
    pfm_en = 1'b0;
    tick();
    pfm_en = 1'b1;
    strobe(10);
    push("R9", 0, 0);
    low_run(3);
    push("R9", 0, 1);
    below_low = 1'b1;
    tick(); below_low = 1'b0;

    // R3 default run length with a fresh entry duty
    run_len = '0;
    pwm_duty = 8'h33;
    low_run(19);
    push("R3", 0, 0);
    strobe(10);
    push("R3", 0, 1);
    push("R10", 3, 'h33);

    tick(); tick();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule